// File: doc/BRIEF.md
# Sample-Period Interrupt Counter

This block counts sample periods down from a programmed value and raises a host interrupt each time the count runs out. A buffer controller uses it to learn when a DMA buffer has filled, without counting transfers itself. Software programs a 16-bit base count through a byte-wide write port. The lower byte is staged first. The upper-byte write then loads the whole value into the running counter.

On every qualifying sample period the counter steps down by one. A qualifying period found at zero is an underflow. On underflow the counter reloads from the base registers and the interrupt is raised. A write strobe to the status register acknowledges the interrupt. Which sample periods qualify depends on the mode input. In compatibility mode, any period in which playback or capture is enabled qualifies. In expanded mode, only periods in which a playback DMA transfer happened qualify.

The interrupt is kept by a two-state machine:
- `IRQ_IDLE` is the idle state and `IRQ_PEND` is the pending state.
- Transition RAISE goes from `IRQ_IDLE` to `IRQ_PEND` on underflow.
- Transition ACK goes from `IRQ_PEND` to `IRQ_IDLE` on a status write when no underflow occurs in the same cycle.
- Transition HOLD keeps the current state in every other case.

Top module: `smp_irq_counter`

## Requirements
- R1: A lower-byte write (`wr_en`=1, `wr_hi`=0) only stages the byte. It changes neither `cur_count` nor `irq`.
- R2: An upper-byte write (`wr_en`=1, `wr_hi`=1) stores the byte. In the next cycle, `cur_count` shows {written byte in bits 15:8, staged lower byte in bits 7:0}. This load takes priority over a step in the same cycle.
- R3: In compatibility mode (`mode_exp`=0), a cycle with `smp_tick`=1 is a step when `play_en` or `cap_en` is 1. In this mode `play_dma` is ignored.
- R4: In expanded mode (`mode_exp`=1), a step needs both `smp_tick`=1 and `play_dma`=1. In this mode `play_en` and `cap_en` alone cause no step.
- R5: A step on a nonzero count lowers `cur_count` by exactly one in the next cycle.
- R6: A step on a zero count is an underflow. It reloads `cur_count` from the base registers and sets `irq` in the next cycle.
- R7: A status write (`stat_wr`=1) clears `irq` in the next cycle. If an underflow happens in the same cycle, `irq` stays high.
- R8: After reset, the base registers and `cur_count` are zero and `irq` is low.
- R9: In a cycle with neither a step nor an upper-byte load, `cur_count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Base-count byte write strobe |
| wr_hi | input | 1 | Byte select: 0 lower, 1 upper |
| wr_data | input | 8 | Byte written |
| stat_wr | input | 1 | Status register write strobe; acknowledges interrupt |
| smp_tick | input | 1 | One-cycle pulse per sample period |
| play_en | input | 1 | Playback enabled |
| cap_en | input | 1 | Capture enabled |
| mode_exp | input | 1 | 0 compatibility mode, 1 expanded mode |
| play_dma | input | 1 | Playback DMA transfer occurred in this sample period |
| irq | output | 1 | Host interrupt |
| cur_count | output | 16 | Current count value |

## Verification
An acknowledge and a fresh underflow can land in the same clock. The bench provokes this in two steps. It first takes a zero base count to underflow, which leaves the interrupt pending. It then strobes the status write in the very cycle of a second qualifying sample period at zero. The result is judged correct when `irq` is still high and the count has reloaded afterwards. A lone status write in the next vector must then drop `irq`.

// File: rtl/smp_irq_pkg.sv
package smp_irq_pkg;
    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/smp_base_regs.sv
module smp_base_regs #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [2*BYTE_W-1:0] base,
    output logic                load,
    output logic [2*BYTE_W-1:0] load_val
);
    logic [BYTE_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            if (wr_hi) hi_q <= wr_data;
            else       lo_q <= wr_data;
        end
    end

    always_comb begin
        base     = {hi_q, lo_q};
        load     = wr_en && wr_hi;
        load_val = {wr_data, lo_q};
    end
endmodule

// File: rtl/smp_step_gate.sv
module smp_step_gate (
    input  logic smp_tick,
    input  logic play_en,
    input  logic cap_en,
    input  logic mode_exp,
    input  logic play_dma,
    output logic step
);
    always_comb begin
        if (mode_exp) step = smp_tick && play_dma;              // R4
        else          step = smp_tick && (play_en || cap_en);   // R3
    end
endmodule

// File: rtl/smp_down_counter.sv
module smp_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic [CNT_W-1:0] base,
    output logic [CNT_W-1:0] cnt,
    output logic             underflow
);
    logic at_zero;

    always_comb begin
        at_zero   = (cnt == '0);
        underflow = step && at_zero && !load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (underflow) cnt <= base;
        else if (step)      cnt <= cnt - 1'b1;
    end

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt == '0) |=> cnt == $past(base));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt));
endmodule

// File: rtl/smp_irq_fsm.sv
module smp_irq_fsm
    import smp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise)         state_d = IRQ_PEND;  // RAISE
            IRQ_PEND: if (ack && !raise) state_d = IRQ_IDLE;  // ACK
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb irq = (state_q == IRQ_PEND);

    p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> irq);
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !raise) |=> !irq);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
endmodule

// File: rtl/smp_irq_counter.sv
module smp_irq_counter #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                stat_wr,
    input  logic                smp_tick,
    input  logic                play_en,
    input  logic                cap_en,
    input  logic                mode_exp,
    input  logic                play_dma,
    output logic                irq,
    output logic [2*BYTE_W-1:0] cur_count
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] base, load_val;
    logic             load, step, underflow;

    smp_base_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .base(base), .load(load), .load_val(load_val)
    );

    smp_step_gate u_gate (
        .smp_tick(smp_tick), .play_en(play_en), .cap_en(cap_en),
        .mode_exp(mode_exp), .play_dma(play_dma), .step(step)
    );

    smp_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .step(step), .base(base), .cnt(cur_count), .underflow(underflow)
    );

    smp_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .raise(underflow), .ack(stat_wr), .irq(irq)
    );

    p_hi_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> cur_count[CNT_W-1:BYTE_W] == $past(wr_data));
    p_lo_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && !smp_tick) |=> $stable(cur_count));
    p_expanded_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_exp && !play_dma && !(wr_en && wr_hi)) |=> $stable(cur_count));
endmodule

// File: tb/test_smp_irq_counter.sv
module test_smp_irq_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_hi = 0, stat_wr = 0, smp_tick = 0;
    logic        play_en = 0, cap_en = 0, mode_exp = 0, play_dma = 0;
    logic [7:0]  wr_data = '0;
    logic        irq;
    logic [15:0] cur_count;
    int          n_vec = 0, n_bad = 0;

    always #2 clk = ~clk;

    smp_irq_counter i_smp_irq_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .stat_wr(stat_wr), .smp_tick(smp_tick),
        .play_en(play_en), .cap_en(cap_en), .mode_exp(mode_exp),
        .play_dma(play_dma), .irq(irq), .cur_count(cur_count)
    );

    // {req[3:0], wlo, whi, stat, tick, pe, ce, mode, dma, data[7:0], exp_cnt[15:0], exp_irq}
    localparam int NV = 22;
    localparam logic [36:0] VEC [NV] = '{
        {4'd1, 4'b1000, 4'b0000, 8'h03, 16'h0000, 1'b0}, // R1 stage low only
        {4'd2, 4'b0100, 4'b0000, 8'h00, 16'h0003, 1'b0}, // R2 load
        {4'd3, 4'b0001, 4'b1000, 8'h00, 16'h0002, 1'b0}, // R3 playback
        {4'd3, 4'b0001, 4'b0100, 8'h00, 16'h0001, 1'b0}, // R3 capture
        {4'd3, 4'b0001, 4'b0001, 8'h00, 16'h0001, 1'b0}, // R3 dma ignored
        {4'd5, 4'b0001, 4'b1000, 8'h00, 16'h0000, 1'b0}, // R5
        {4'd6, 4'b0001, 4'b1000, 8'h00, 16'h0003, 1'b1}, // R6 underflow
        {4'd7, 4'b0010, 4'b0000, 8'h00, 16'h0003, 1'b0}, // R7 ack
        {4'd1, 4'b1000, 4'b0000, 8'h01, 16'h0003, 1'b0}, // R1
        {4'd2, 4'b0100, 4'b0000, 8'h01, 16'h0101, 1'b0}, // R2
        {4'd4, 4'b0001, 4'b1110, 8'h00, 16'h0101, 1'b0}, // R4 no dma
        {4'd4, 4'b0001, 4'b0011, 8'h00, 16'h0100, 1'b0}, // R4 dma
        {4'd9, 4'b0000, 4'b0011, 8'h00, 16'h0100, 1'b0}, // R9 no tick
        {4'd1, 4'b1000, 4'b0000, 8'h00, 16'h0100, 1'b0}, // R1
        {4'd2, 4'b0100, 4'b0000, 8'h00, 16'h0000, 1'b0}, // R2 zero base
        {4'd6, 4'b0001, 4'b0100, 8'h00, 16'h0000, 1'b1}, // R6 reload zero
        {4'd7, 4'b0011, 4'b0100, 8'h00, 16'h0000, 1'b1}, // R7 ack+underflow
        {4'd7, 4'b0010, 4'b0000, 8'h00, 16'h0000, 1'b0}, // R7 ack
        {4'd1, 4'b1000, 4'b0000, 8'hFF, 16'h0000, 1'b0}, // R1
        {4'd2, 4'b0100, 4'b0000, 8'hFF, 16'hFFFF, 1'b0}, // R2 full
        {4'd2, 4'b0101, 4'b1000, 8'h12, 16'h12FF, 1'b0}, // R2 load beats step
        {4'd5, 4'b0001, 4'b1000, 8'h00, 16'h12FE, 1'b0}  // R5
    };

    task automatic check(input int req, input logic [15:0] ec, input logic ei);
        n_vec++;
        if (cur_count !== ec || irq !== ei) begin
            n_bad++;
            $display("FAIL R%0d: count=%h irq=%b expected count=%h irq=%b",
                     req, cur_count, irq, ec, ei);
        end
    endtask

    task automatic drive(input logic [7:0] ctl, input logic [7:0] d);
        @(negedge clk);
        {wr_en, wr_hi, stat_wr, smp_tick, play_en, cap_en, mode_exp, play_dma} = ctl;
        wr_hi   = ctl[6];
        wr_en   = ctl[7] | ctl[6];
        wr_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(8, 16'h0000, 1'b0);              // R8 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][32:25], VEC[i][24:17]);
            check(int'(VEC[i][36:33]), VEC[i][16:1], VEC[i][0]);
        end
        // R7: acknowledge while idle leaves irq low, count held
        drive(8'b0010_0000, 8'h00);
        check(7, 16'h12FE, 1'b0);
        // R9: idle cycle holds
        drive(8'b0000_1000, 8'h00);
        check(9, 16'h12FE, 1'b0);
        // R8: reset mid-run after a pending interrupt
        drive(8'b0100_0000, 8'h00);            // base = 0x00FF, count = 0x00FF
        drive(8'b1000_0000, 8'h00);            // low = 0
        drive(8'b0100_0000, 8'h00);            // count 0
        drive(8'b0001_1000, 8'h00);            // underflow
        check(6, 16'h0000, 1'b1);
        @(negedge clk);
        {wr_en, wr_hi, stat_wr, smp_tick} = '0;
        rst_n = 1'b0;
        #1;
        check(8, 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(8'b0001_1000, 8'h00);            // R8 base cleared: reload 0
        check(8, 16'h0000, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule